// File: doc/BRIEF.md
# Earliest-free bank mask generator

This block looks at a snapshot of per-bank "free-at" times, and of which banks have pending work, and reports every pending bank that becomes available soonest. A memory scheduler uses the result to pick, among requests that miss the open row, those that aim at the earliest usable bank. Banks are organised as ranks of banks. Each bank has a flat number, `rank * BANKS_PER_RANK + bank`, and that number is its bit position in a fixed 64-bit mask.

The pending flags come from two sources, which are OR-ed together. One is a direct per-bank flag vector. The other is a small front stage that reads the bank numbers of the queued entries. A snapshot enters through a valid/ready input and is captured on the cycle that `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle, so a producer must hold its data and `in_valid` until that cycle; inputs seen at any other time are ignored. The scan then visits one bank per cycle, in flat order.

The result is offered with `out_valid`. It stays valid, with the mask unchanged, until the consumer raises `out_ready`. The block takes no new snapshot until the result has been taken.

Top module: `emb_top`

## Requirements
- R1: Mask bit k stands for flat bank k = rank * BANKS_PER_RANK + bank. The mask is 64 bits wide, and bits at or above NUM_RANKS * BANKS_PER_RANK are always 0.
- R2: Only banks whose pending flag is set can appear in the mask.
- R3: Bank k is pending if `wait_i[k]` is 1, or if some queue entry e has `q_vld_i[e]` = 1 and its 6-bit id `q_bank_i[6e+5:6e]` equals k. Entries with the valid bit low are ignored, and so are entries whose id is not below the bank count.
- R4: A pending bank whose free-at time is strictly below every earlier pending bank's time removes all earlier bits from the mask.
- R5: Every pending bank whose free-at time equals the smallest pending time is in the mask.
- R6: Times are unsigned, with the bank k time at `free_at_i[k*TIME_W +: TIME_W]`. A pending bank at the all-ones time is still selected when no pending bank is earlier.
- R7: With no pending bank the mask is all zeros.
- R8: `in_ready` is 1 only while idle. Inputs are captured on the accepting edge, and any change to them later in the same operation has no effect on its result.
- R9: `out_valid` rises exactly NUM_RANKS * BANKS_PER_RANK clock cycles after the accepting edge. While `out_ready` is 0 it stays 1 and the mask does not change. On the cycle after an accepting `out_ready`, the block is idle with `in_ready` = 1.
- R10: After reset, `in_ready` = 1, `out_valid` = 0 and the mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Snapshot offered |
| in_ready | output | 1 | Block idle, snapshot will be taken |
| free_at_i | input | NUM_RANKS*BANKS_PER_RANK*TIME_W | Free-at time per flat bank |
| wait_i | input | NUM_RANKS*BANKS_PER_RANK | Direct pending flag per flat bank |
| q_bank_i | input | QDEPTH*6 | Flat bank id of each queue entry |
| q_vld_i | input | QDEPTH | Queue entry holds a request |
| out_valid | output | 1 | Mask result available |
| out_ready | input | 1 | Consumer takes the result |
| mask_o | output | 64 | Banks tied at the earliest pending free-at time |

## Verification
A design that chose only one argmin would drop banks from the all-equal and all-ones cases, and a running minimum that started below the maximum would return an empty mask when every pending bank sits at the largest time. Keeping stale bits on a strictly smaller time shows up in the case where an earlier bank is overtaken by two later tied banks. The queue-only case uses an invalid entry and an out-of-range id, so a front stage that ignores valid bits or folds ids into range sets a wrong bit. The inputs are scrambled after acceptance and the consumer holds back, so a design that reads its inputs live, or lets the result drift under back-pressure, returns the wrong mask or latency.

// File: rtl/emb_pkg.sv
package emb_pkg;
  localparam int MASK_W = 64;
  localparam int ID_W   = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } emb_state_e;
endpackage

// File: rtl/emb_wait_gen.sv
module emb_wait_gen #(
  parameter int NB     = 16,
  parameter int QDEPTH = 4,
  parameter int ID_W   = 6
) (
  input  logic [NB-1:0]          direct_wait,
  input  logic [QDEPTH*ID_W-1:0] q_id,
  input  logic [QDEPTH-1:0]      q_vld,
  output logic [NB-1:0]          waiting
);
  // Each bank is pending when flagged directly or targeted by a live entry.
  // Ids at or above NB match no bank and therefore drop out.
  always_comb begin
    waiting = direct_wait;
    for (int b = 0; b < NB; b++) begin
      for (int e = 0; e < QDEPTH; e++) begin
        if (q_vld[e] && (q_id[e*ID_W +: ID_W] == ID_W'(b))) begin
          waiting[b] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/emb_scan.sv
module emb_scan #(
  parameter int NB     = 16,
  parameter int TIME_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NB*TIME_W-1:0] free_flat,
  input  logic [NB-1:0]        wait_vec,
  output logic                 done,
  output logic [NB-1:0]        mask_nx
);
  localparam int IDXW = (NB > 1) ? $clog2(NB) : 1;

  logic                 scanning;
  logic [IDXW-1:0]      idx;
  logic [NB*TIME_W-1:0] free_q;
  logic [NB-1:0]        wait_q;
  logic [TIME_W-1:0]    min_q, min_nx;
  logic [NB-1:0]        mask_q;
  logic [TIME_W-1:0]    cur_t;
  logic                 cur_w;

  assign cur_t = free_q[int'(idx)*TIME_W +: TIME_W];
  assign cur_w = wait_q[idx];
  assign done  = scanning && (idx == IDXW'(NB-1));

  // One bank per cycle: a strictly earlier time restarts the set,
  // an equal time joins it.
  always_comb begin
    min_nx  = min_q;
    mask_nx = mask_q;
    if (cur_w) begin
      if (cur_t < min_q) begin
        mask_nx      = '0;
        mask_nx[idx] = 1'b1;
        min_nx       = cur_t;
      end else if (cur_t == min_q) begin
        mask_nx[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scanning <= 1'b0;
      idx      <= '0;
      free_q   <= '0;
      wait_q   <= '0;
      min_q    <= '1;
      mask_q   <= '0;
    end else if (start && !scanning) begin
      scanning <= 1'b1;
      idx      <= '0;
      free_q   <= free_flat;
      wait_q   <= wait_vec;
      min_q    <= '1;
      mask_q   <= '0;
    end else if (scanning) begin
      min_q  <= min_nx;
      mask_q <= mask_nx;
      if (done) begin
        scanning <= 1'b0;
        idx      <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  AST_MASK_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    scanning |-> ((mask_q & ~wait_q) == '0)); // R2

  AST_MIN_NONINCREASING: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && $past(scanning)) |-> (min_q <= $past(min_q))); // R4

  AST_STRICT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && cur_w && (cur_t < min_q)) |=> ($countones(mask_q) == 1)); // R4

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (wait_q == '0)) |=> (mask_q == '0)); // R7
endmodule

// File: rtl/emb_top.sv
module emb_top #(
  parameter int NUM_RANKS      = 2,
  parameter int BANKS_PER_RANK = 8,
  parameter int TIME_W         = 16,
  parameter int QDEPTH         = 4
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         in_valid,
  output logic                                         in_ready,
  input  logic [NUM_RANKS*BANKS_PER_RANK*TIME_W-1:0]   free_at_i,
  input  logic [NUM_RANKS*BANKS_PER_RANK-1:0]          wait_i,
  input  logic [QDEPTH*emb_pkg::ID_W-1:0]              q_bank_i,
  input  logic [QDEPTH-1:0]                            q_vld_i,
  output logic                                         out_valid,
  input  logic                                         out_ready,
  output logic [emb_pkg::MASK_W-1:0]                   mask_o
);
  import emb_pkg::*;

  localparam int NB = NUM_RANKS * BANKS_PER_RANK;

  emb_state_e       st;
  logic [NB-1:0]    waiting;
  logic [NB-1:0]    core_mask;
  logic             core_done;
  logic [NB-1:0]    mask_q;
  logic             accept;

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_DONE);
  assign accept    = in_valid && in_ready;
  assign mask_o    = MASK_W'(mask_q);

  emb_wait_gen #(.NB(NB), .QDEPTH(QDEPTH), .ID_W(ID_W)) i_wait_gen (
    .direct_wait (wait_i),
    .q_id        (q_bank_i),
    .q_vld       (q_vld_i),
    .waiting     (waiting)
  );

  emb_scan #(.NB(NB), .TIME_W(TIME_W)) i_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .free_flat (free_at_i),
    .wait_vec  (waiting),
    .done      (core_done),
    .mask_nx   (core_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mask_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) st <= ST_SCAN;
        ST_SCAN: if (core_done) begin
          st     <= ST_DONE;
          mask_q <= core_mask;
        end
        ST_DONE: if (out_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_o >> NB) == '0)); // R1

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(mask_o))); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept) |-> !in_ready); // R8

  AST_RETURN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid)); // R9
endmodule

// File: tb/test_emb_top.sv
module test_emb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 2, BPR = 8, TW = 16, QD = 4;
  localparam int NB = NR * BPR;

  typedef struct packed {
    logic [15:0] mul;
    logic [15:0] add;
    logic [16:0] modv;
    logic [15:0] wt;
    logic [23:0] qid;
    logic [3:0]  qv;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd3,  16'd1,     17'd7,     16'hFFFF, 24'h0, 4'h0},
    '{16'd5,  16'd2,     17'd4,     16'h0F0F, 24'h0, 4'h0},
    '{16'd0,  16'd9,     17'd100,   16'hA5A5, 24'h0, 4'h0},
    '{16'd7,  16'd3,     17'd11,    16'h0000, {6'd3, 6'd40, 6'd12, 6'd5}, 4'b1011},
    '{16'd1,  16'd0,     17'd65536, 16'h8001, 24'h0, 4'h0},
    '{16'd13, 16'd65530, 17'd65536, 16'h7FFE, 24'h0, 4'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [NB*TW-1:0] free_at_i = '0;
  logic [NB-1:0]    wait_i = '0;
  logic [QD*6-1:0]  q_bank_i = '0;
  logic [QD-1:0]    q_vld_i = '0;
  logic [63:0]      mask_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  emb_top #(.NUM_RANKS(NR), .BANKS_PER_RANK(BPR), .TIME_W(TW), .QDEPTH(QD)) i_emb_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .free_at_i(free_at_i), .wait_i(wait_i), .q_bank_i(q_bank_i), .q_vld_i(q_vld_i),
    .out_valid(out_valid), .out_ready(out_ready), .mask_o(mask_o)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: derive pending set, find minimum, then collect equals.
  function automatic logic [63:0] model(input logic [NB*TW-1:0] f, input logic [NB-1:0] w,
                                        input logic [QD*6-1:0] qi, input logic [QD-1:0] qv);
    logic [NB-1:0] pend = w;
    logic found = 1'b0;
    logic [TW-1:0] mn = '0;
    logic [63:0] m = '0;
    for (int e = 0; e < QD; e++)
      if (qv[e] && int'(qi[e*6 +: 6]) < NB) pend[int'(qi[e*6 +: 6])] = 1'b1;
    for (int b = 0; b < NB; b++)
      if (pend[b] && (!found || f[b*TW +: TW] < mn)) begin
        mn = f[b*TW +: TW];
        found = 1'b1;
      end
    for (int b = 0; b < NB; b++)
      if (pend[b] && f[b*TW +: TW] == mn) m[b] = 1'b1;
    return m;
  endfunction

  task automatic run(input logic [NB*TW-1:0] f, input logic [NB-1:0] w, input logic [QD*6-1:0] qi,
                     input logic [QD-1:0] qv, input logic [63:0] exp, input string tag, input int hold);
    int cnt = 0;
    @(negedge clk);
    free_at_i = f; wait_i = w; q_bank_i = qi; q_vld_i = qv;
    in_valid = 1'b1; out_ready = 1'b0;
    check(in_ready == 1'b1, "R8 ready when idle", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    // R8: scramble the inputs after acceptance
    free_at_i = '0; wait_i = '1; q_vld_i = '1; q_bank_i = '0;
    in_valid = (hold > 0);
    while (!out_valid && cnt < 1000) begin
      @(posedge clk); cnt++; @(negedge clk);
      if (!out_valid) check(in_ready == 1'b0, "R8 busy not ready", 64'(in_ready), 64'd0);
    end
    check(cnt == NB, "R9 latency", 64'(cnt), 64'(NB));
    check(mask_o == exp, tag, mask_o, exp);
    check((mask_o >> NB) == 64'd0, "R1 upper bits zero", mask_o, exp);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(out_valid && mask_o == exp && !in_ready, "R9 hold under back-pressure", mask_o, exp);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R9 back to idle", {62'd0, out_valid, in_ready}, 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NB*TW-1:0] f;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check(in_ready && !out_valid && mask_o == 64'd0, "R10 reset state", mask_o, 64'd0);

    // Table of generated patterns, R5 R6 R3 R2
    for (int v = 0; v < 6; v++) begin
      for (int b = 0; b < NB; b++)
        f[b*TW +: TW] = TW'((b * int'(VECS[v].mul) + int'(VECS[v].add)) % int'(VECS[v].modv));
      run(f, VECS[v].wt, VECS[v].qid, VECS[v].qv,
          model(f, VECS[v].wt, VECS[v].qid, VECS[v].qv), "R5 R2 table vector", 0);
    end

    // R7: nothing pending
    run('1, '0, '0, '0, 64'd0, "R7 empty mask", 0);

    // R6: all pending banks at the largest time
    run('1, 16'h0F3C, '0, '0, 64'h0F3C, "R6 all-ones time selected", 0);

    // R4 and R1: bank 3 overtaken by tied banks 10 (rank 1 bank 2) and 12
    for (int b = 0; b < NB; b++) f[b*TW +: TW] = 16'd100;
    f[0*TW +: TW] = 16'd50; f[3*TW +: TW] = 16'd5;
    f[10*TW +: TW] = 16'd2; f[12*TW +: TW] = 16'd2;
    run(f, 16'h1409, '0, '0, 64'h1400, "R4 strict restart", 0);

    // R3: queue only; entry 0 id 40 out of range, entry 1 id 7 invalid, entry 2 id 9
    run('0, '0, {6'd0, 6'd9, 6'd7, 6'd40}, 4'b0101, 64'h0200, "R3 queue front stage", 0);

    // R9 and R8: back-pressure with a new offer held during busy
    run(f, 16'h0008, '0, '0, 64'h0008, "R9 single bank", 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule